// File: doc/BRIEF.md
# Decode-Once Pipelined Control Carrier

This block produces the control word for each instruction once, while the instruction sits in the register-read/decode stage. It then moves that word forward in lockstep with the instruction through the three pipeline registers that follow decode. The register between execute and memory drops the execute controls. The register between memory and writeback drops the memory controls. As a result, each downstream stage sees only its own controls, a valid flag and the tag that identifies the instruction. The datapath that uses these controls (ALU, memories, register file) sits outside the block.

Instructions come in over a valid/ready handshake. The back-pressure rule is as follows. `if_ready` is low exactly while `stall` is asserted. During that time the fetch side must hold `if_valid`, `if_opcode` and `if_tag` steady, and no transfer takes place. While the stall lasts, the instruction in decode is held and a no-op enters the execute stage. The stages beyond execute keep draining. A separate `bubble` input discards the instruction currently in decode, for example after a control hazard, without holding back fetch.

Every instruction that writes the register file does so from the last stage, and that includes register-register operations. At most one instruction occupies the writeback stage in any cycle, so one write port is enough.

Top module: `ctrl_pipe`

## Requirements
- R1: A synchronous reset leaves `ex_valid`, `mem_valid`, `wb_valid`, `mem_store_en`, `mem_branch_en` and `wb_rf_wr_en` at 0 after the clock edge on which `rst` is high.
- R2: An instruction accepted on edge k (`if_valid && if_ready`) appears at the execute outputs after edge k+1, at the memory outputs after k+2 and at the writeback outputs after k+3. At each of these stages the valid flag is 1 and the tag is unchanged.
- R3: The execute controls (`ex_alu_sel`: 0 add, 1 subtract, 2 use function field, 3 or), `ex_imm_operand`, `mem_store_en`, `mem_branch_en`, `wb_load_sel` and `wb_rf_wr_en` are decoded per opcode as follows. 0x00 register op: sel 2, reg operand, write. 0x23 load: sel 0, imm operand, load select, write. 0x2B store: sel 0, imm operand, store. 0x04 branch-equal: sel 1, reg operand, branch. 0x08 add-immediate: sel 0, imm operand, write. 0x0D or-immediate: sel 3, imm operand, write.
- R4: `ex_sign_ext` is 0 for or-immediate and for the register op. It is 1 for add-immediate, load, store and branch-equal.
- R5: `ex_dest_rd` is 1 for the register op and for load. It is 0 for add-immediate, or-immediate, store and branch-equal.
- R6: A register-file write enable appears only at the writeback outputs. A load followed directly by a register op produces write enables in two consecutive cycles, one per cycle.
- R7: Any other opcode passes down the pipe with its valid flag set, but every control output is 0.
- R8: With `stall` high on an edge, the decode stage keeps its instruction and the execute stage receives a no-op (valid 0, all controls 0). The memory and writeback stages still advance. The held instruction reaches execute on the first edge after `stall` falls.
- R9: With `bubble` high and `stall` low on an edge, the instruction in decode never reaches execute, and the decode stage loads the incoming instruction.
- R10: A slot with its valid flag at 0, at any stage, shows all controls and the tag at 0.
- R11: `if_ready` equals the inverse of `stall`, and no instruction is taken while `if_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| if_valid | input | 1 | Fetch side offers an instruction |
| if_ready | output | 1 | Decode stage can take an instruction |
| if_opcode | input | 6 | Opcode of the offered instruction |
| if_tag | input | TAG_W | Identifier carried with the instruction |
| stall | input | 1 | Hold decode, insert a no-op into execute |
| bubble | input | 1 | Discard the instruction now in decode |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_tag | output | TAG_W | Tag in execute |
| ex_sign_ext | output | 1 | Immediate extension: 1 sign, 0 zero |
| ex_imm_operand | output | 1 | Second ALU operand is the immediate |
| ex_alu_sel | output | 2 | ALU operation select |
| ex_dest_rd | output | 1 | Destination is the rd field, else rt |
| mem_valid | output | 1 | Memory slot holds an instruction |
| mem_tag | output | TAG_W | Tag in memory |
| mem_store_en | output | 1 | Data memory write enable |
| mem_branch_en | output | 1 | Branch-equal resolves here |
| wb_valid | output | 1 | Writeback slot holds an instruction |
| wb_tag | output | TAG_W | Tag in writeback |
| wb_load_sel | output | 1 | Write data comes from memory |
| wb_rf_wr_en | output | 1 | Register-file write enable |

## Verification
Suppose a pipeline register loses, duplicates or reorders its contents. The wrong tag or valid flag then shows at the next stage's outputs one edge later, and at writeback no more than three edges after the instruction was accepted. A wrong entry in the decode table shows as soon as the affected opcode reaches execute, one edge after it enters decode. A stall or bubble that fails to clear the slot shows at once as a valid execute slot or a live enable where a no-op was due. A stall that fails to hold decode shows one edge after the stall falls, when the execute stage presents the wrong tag.

// File: rtl/ctrl_pipe_pkg.sv
package ctrl_pipe_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_SUB   = 2'd1,
    ALU_FUNCT = 2'd2,
    ALU_OR    = 2'd3
  } alu_sel_e;

  typedef struct packed {
    logic     sign_ext;
    logic     imm_operand;
    alu_sel_e alu_sel;
    logic     dest_rd;
  } ex_ctl_t;

  typedef struct packed {
    logic store_en;
    logic branch_en;
  } mem_ctl_t;

  typedef struct packed {
    logic load_sel;
    logic rf_wr_en;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_t;

  localparam int EX_CTL_W  = $bits(ex_ctl_t);
  localparam int MEM_CTL_W = $bits(mem_ctl_t);
  localparam int WB_CTL_W  = $bits(wb_ctl_t);
  localparam int CTL_W     = $bits(ctl_t);
endpackage

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pipe_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctl_t             ctl
);
  always_comb begin
    ctl = '0;
    unique case (opcode)
      OPC_REG: begin
        ctl.ex.alu_sel = ALU_FUNCT;
        ctl.ex.dest_rd = 1'b1;
        ctl.wb.rf_wr_en = 1'b1;
      end
      OPC_LOAD: begin
        ctl.ex.sign_ext    = 1'b1;
        ctl.ex.imm_operand = 1'b1;
        ctl.ex.alu_sel     = ALU_ADD;
        ctl.ex.dest_rd     = 1'b1;
        ctl.wb.load_sel    = 1'b1;
        ctl.wb.rf_wr_en    = 1'b1;
      end
      OPC_STORE: begin
        ctl.ex.sign_ext    = 1'b1;
        ctl.ex.imm_operand = 1'b1;
        ctl.ex.alu_sel     = ALU_ADD;
        ctl.mem.store_en   = 1'b1;
      end
      OPC_BREQ: begin
        ctl.ex.sign_ext   = 1'b1;
        ctl.ex.alu_sel    = ALU_SUB;
        ctl.mem.branch_en = 1'b1;
      end
      OPC_ADDI: begin
        ctl.ex.sign_ext    = 1'b1;
        ctl.ex.imm_operand = 1'b1;
        ctl.ex.alu_sel     = ALU_ADD;
        ctl.wb.rf_wr_en    = 1'b1;
      end
      OPC_ORI: begin
        ctl.ex.imm_operand = 1'b1;
        ctl.ex.alu_sel     = ALU_OR;
        ctl.wb.rf_wr_en    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  // R3
  always_comb begin
    store_vs_write_chk: assert (!(ctl.mem.store_en && ctl.wb.rf_wr_en));
  end
endmodule

// File: rtl/pipe_slot.sv
module pipe_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic         squash,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (squash) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (advance) begin
      out_valid <= in_valid;
      out_data  <= in_valid ? in_data : '0;
    end
  end

  // R10
  empty_slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0));

  // R8
  hold_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!advance && !squash) |=> ($stable(out_valid) && $stable(out_data)));

  // R9
  squash_slot_chk: assert property (@(posedge clk) disable iff (rst)
    squash |=> !out_valid);
endmodule

// File: rtl/ctrl_pipe.sv
module ctrl_pipe
  import ctrl_pipe_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             if_valid,
  output logic             if_ready,
  input  logic [OPC_W-1:0] if_opcode,
  input  logic [TAG_W-1:0] if_tag,
  input  logic             stall,
  input  logic             bubble,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag,
  output logic             ex_sign_ext,
  output logic             ex_imm_operand,
  output logic [1:0]       ex_alu_sel,
  output logic             ex_dest_rd,
  output logic             mem_valid,
  output logic [TAG_W-1:0] mem_tag,
  output logic             mem_store_en,
  output logic             mem_branch_en,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic             wb_load_sel,
  output logic             wb_rf_wr_en
);
  localparam int FD_W = OPC_W + TAG_W;
  localparam int DX_W = TAG_W + CTL_W;
  localparam int XM_W = TAG_W + MEM_CTL_W + WB_CTL_W;
  localparam int MW_W = TAG_W + WB_CTL_W;

  // decode-stage register: opcode and tag
  logic             fd_valid;
  logic [FD_W-1:0]  fd_data;
  logic [OPC_W-1:0] fd_opcode;
  logic [TAG_W-1:0] fd_tag;

  assign if_ready = !stall;

  pipe_slot #(.W(FD_W)) u_fd (
    .clk(clk), .rst(rst), .advance(!stall), .squash(1'b0),
    .in_valid(if_valid), .in_data({if_opcode, if_tag}),
    .out_valid(fd_valid), .out_data(fd_data)
  );
  assign {fd_opcode, fd_tag} = fd_data;

  ctl_t dec_ctl;
  ctrl_decoder u_dec (.opcode(fd_opcode), .ctl(dec_ctl));

  // execute-stage register: full control word
  logic             dx_valid;
  logic [DX_W-1:0]  dx_data;
  logic [TAG_W-1:0] dx_tag;
  ctl_t             dx_ctl;

  pipe_slot #(.W(DX_W)) u_dx (
    .clk(clk), .rst(rst), .advance(1'b1), .squash(stall || bubble),
    .in_valid(fd_valid), .in_data({fd_tag, dec_ctl}),
    .out_valid(dx_valid), .out_data(dx_data)
  );
  assign {dx_tag, dx_ctl} = dx_data;

  // memory-stage register: execute controls dropped
  logic             xm_valid;
  logic [XM_W-1:0]  xm_data;
  logic [TAG_W-1:0] xm_tag;
  mem_ctl_t         xm_mem;
  wb_ctl_t          xm_wb;

  pipe_slot #(.W(XM_W)) u_xm (
    .clk(clk), .rst(rst), .advance(1'b1), .squash(1'b0),
    .in_valid(dx_valid), .in_data({dx_tag, dx_ctl.mem, dx_ctl.wb}),
    .out_valid(xm_valid), .out_data(xm_data)
  );
  assign {xm_tag, xm_mem, xm_wb} = xm_data;

  // writeback-stage register: only write controls remain
  logic             mw_valid;
  logic [MW_W-1:0]  mw_data;
  logic [TAG_W-1:0] mw_tag;
  wb_ctl_t          mw_wb;

  pipe_slot #(.W(MW_W)) u_mw (
    .clk(clk), .rst(rst), .advance(1'b1), .squash(1'b0),
    .in_valid(xm_valid), .in_data({xm_tag, xm_wb}),
    .out_valid(mw_valid), .out_data(mw_data)
  );
  assign {mw_tag, mw_wb} = mw_data;

  assign ex_valid       = dx_valid;
  assign ex_tag         = dx_tag;
  assign ex_sign_ext    = dx_ctl.ex.sign_ext;
  assign ex_imm_operand = dx_ctl.ex.imm_operand;
  assign ex_alu_sel     = dx_ctl.ex.alu_sel;
  assign ex_dest_rd     = dx_ctl.ex.dest_rd;
  assign mem_valid      = xm_valid;
  assign mem_tag        = xm_tag;
  assign mem_store_en   = xm_mem.store_en;
  assign mem_branch_en  = xm_mem.branch_en;
  assign wb_valid       = mw_valid;
  assign wb_tag         = mw_tag;
  assign wb_load_sel    = mw_wb.load_sel;
  assign wb_rf_wr_en    = mw_wb.rf_wr_en;

  // R2
  ex_to_mem_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    ex_valid |=> (mem_valid && mem_tag == $past(ex_tag)));

  // R2
  mem_to_wb_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> (wb_valid && wb_tag == $past(mem_tag)));

  // R8
  stall_noop_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex_valid && !ex_imm_operand && !ex_dest_rd));

  // R6
  write_only_when_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wb_rf_wr_en |-> wb_valid);
endmodule

// File: tb/ctrl_pipe_tb_top.sv
module ctrl_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic if_valid = 1'b0;
  logic if_ready;
  logic [5:0] if_opcode = '0;
  logic [TAG_W-1:0] if_tag = '0;
  logic stall = 1'b0;
  logic bubble = 1'b0;
  logic ex_valid, ex_sign_ext, ex_imm_operand, ex_dest_rd;
  logic [1:0] ex_alu_sel;
  logic [TAG_W-1:0] ex_tag, mem_tag, wb_tag;
  logic mem_valid, mem_store_en, mem_branch_en;
  logic wb_valid, wb_load_sel, wb_rf_wr_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_pipe #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .if_valid(if_valid), .if_ready(if_ready),
    .if_opcode(if_opcode), .if_tag(if_tag), .stall(stall), .bubble(bubble),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_sign_ext(ex_sign_ext),
    .ex_imm_operand(ex_imm_operand), .ex_alu_sel(ex_alu_sel),
    .ex_dest_rd(ex_dest_rd), .mem_valid(mem_valid), .mem_tag(mem_tag),
    .mem_store_en(mem_store_en), .mem_branch_en(mem_branch_en),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_load_sel(wb_load_sel),
    .wb_rf_wr_en(wb_rf_wr_en)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected control word per requirements R3/R4/R5/R7:
  // {sign, imm, sel[1:0], dest_rd, store, branch, load_sel, wr}
  function automatic logic [8:0] ref_ctl(logic [5:0] op);
    case (op)
      6'h00: return 9'b0_0_10_1_00_01;
      6'h23: return 9'b1_1_00_1_00_11;
      6'h2B: return 9'b1_1_00_0_10_00;
      6'h04: return 9'b1_0_01_0_01_00;
      6'h08: return 9'b1_1_00_0_00_01;
      6'h0D: return 9'b0_1_11_0_00_01;
      default: return 9'b0;
    endcase
  endfunction

  function automatic bit known_op(logic [5:0] op);
    return op inside {6'h00, 6'h23, 6'h2B, 6'h04, 6'h08, 6'h0D};
  endfunction

  // reference pipeline state
  logic m_fd_v = 0; logic [5:0] m_fd_op = 0; logic [TAG_W-1:0] m_fd_tag = 0;
  logic m_ex_v = 0; logic [TAG_W-1:0] m_ex_tag = 0; logic [8:0] m_ex_ctl = 0;
  logic [5:0] m_ex_op = 0;
  logic m_mem_v = 0; logic [TAG_W-1:0] m_mem_tag = 0; logic [3:0] m_mem_ctl = 0;
  logic m_wb_v = 0; logic [TAG_W-1:0] m_wb_tag = 0; logic [1:0] m_wb_ctl = 0;
  string ex_cause = "R1";
  int wr_run = 0;
  int max_wr_run = 0;

  task automatic model_edge();
    if (rst) begin
      m_fd_v = 0; m_fd_op = 0; m_fd_tag = 0;
      m_ex_v = 0; m_ex_tag = 0; m_ex_ctl = 0; m_ex_op = 0;
      m_mem_v = 0; m_mem_tag = 0; m_mem_ctl = 0;
      m_wb_v = 0; m_wb_tag = 0; m_wb_ctl = 0;
      ex_cause = "R1";
    end else begin
      m_wb_v = m_mem_v; m_wb_tag = m_mem_tag; m_wb_ctl = m_mem_ctl[1:0];
      m_mem_v = m_ex_v; m_mem_tag = m_ex_tag; m_mem_ctl = m_ex_ctl[3:0];
      if (stall || bubble || !m_fd_v) begin
        m_ex_v = 0; m_ex_tag = 0; m_ex_ctl = 0; m_ex_op = 0;
        ex_cause = stall ? "R8" : (bubble ? "R9" : "R10");
      end else begin
        m_ex_v = 1; m_ex_tag = m_fd_tag; m_ex_ctl = ref_ctl(m_fd_op);
        m_ex_op = m_fd_op;
        ex_cause = "R2";
      end
      if (!stall) begin
        m_fd_v = if_valid;
        m_fd_op = if_valid ? if_opcode : 6'h0;
        m_fd_tag = if_valid ? if_tag : '0;
      end
    end
  endtask

  task automatic compare();
    string cl;
    cl = !m_ex_v ? ex_cause : (!known_op(m_ex_op) ? "R7" : "R3");
    chk(ex_cause, "ex_valid", ex_valid, m_ex_v);
    chk("R2", "ex_tag", ex_tag, m_ex_tag);
    chk(cl, "ex_alu_sel", ex_alu_sel, m_ex_ctl[6:5]);
    chk(cl, "ex_imm_operand", ex_imm_operand, m_ex_ctl[7]);
    chk(m_ex_v ? "R4" : cl, "ex_sign_ext", ex_sign_ext, m_ex_ctl[8]);
    chk(m_ex_v ? "R5" : cl, "ex_dest_rd", ex_dest_rd, m_ex_ctl[4]);
    chk("R2", "mem_valid", mem_valid, m_mem_v);
    chk("R2", "mem_tag", mem_tag, m_mem_tag);
    chk(m_mem_v ? "R3" : "R10", "mem_store_en", mem_store_en, m_mem_ctl[3]);
    chk(m_mem_v ? "R3" : "R10", "mem_branch_en", mem_branch_en, m_mem_ctl[2]);
    chk("R2", "wb_valid", wb_valid, m_wb_v);
    chk("R2", "wb_tag", wb_tag, m_wb_tag);
    chk("R3", "wb_load_sel", wb_load_sel, m_wb_ctl[1]);
    chk("R6", "wb_rf_wr_en", wb_rf_wr_en, m_wb_ctl[0]);
    wr_run = wb_rf_wr_en ? wr_run + 1 : 0;
    if (wr_run > max_wr_run) max_wr_run = wr_run;
  endtask

  // called at a negedge: drive, check ready, take the edge, compare
  task automatic step(logic r, logic st, logic bb, logic v, logic [5:0] op,
                      logic [TAG_W-1:0] tg);
    rst = r; stall = st; bubble = bb; if_valid = v; if_opcode = op; if_tag = tg;
    #1;
    chk("R11", "if_ready", if_ready, !st);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    logic [5:0] ops [6];
    ops[0] = 6'h00; ops[1] = 6'h23; ops[2] = 6'h2B;
    ops[3] = 6'h04; ops[4] = 6'h08; ops[5] = 6'h0D;
    @(negedge clk);
    // R1: reset state
    step(1, 0, 0, 1, 6'h23, 8'h11);
    step(1, 0, 0, 1, 6'h23, 8'h12);
    // R3 R7: sweep every opcode, tag = opcode
    for (int o = 0; o < 64; o++) step(0, 0, 0, 1, o[5:0], o[7:0]);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 6'h0, 8'h0);
    // R6: load then register op back to back
    max_wr_run = 0;
    step(0, 0, 0, 1, 6'h23, 8'hA0);
    step(0, 0, 0, 1, 6'h00, 8'hA1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 6'h0, 8'h0);
    chk("R6", "consecutive write cycles", max_wr_run, 2);
    // R8: held instruction appears after a 3-cycle stall
    step(0, 0, 0, 1, 6'h0D, 8'hB0);
    step(0, 1, 0, 1, 6'h08, 8'hB1);
    step(0, 1, 0, 1, 6'h08, 8'hB1);
    step(0, 1, 0, 1, 6'h08, 8'hB1);
    step(0, 0, 0, 1, 6'h08, 8'hB1);
    chk("R8", "held tag reaches execute", ex_tag, 8'hB0);
    // R9: bubble discards decode contents
    step(0, 0, 0, 1, 6'h2B, 8'hC0);
    step(0, 0, 1, 1, 6'h04, 8'hC1);
    chk("R9", "squashed slot", ex_valid, 0);
    step(0, 0, 0, 0, 6'h0, 8'h0);
    chk("R9", "next tag after squash", ex_tag, 8'hC1);
    // mixed pattern sweep
    for (int i = 0; i < 2000; i++) begin
      logic st, bb, v;
      logic [5:0] op;
      lf = nxt(lf); st = (lf[1:0] == 2'b00);
      lf = nxt(lf); bb = (lf[2:0] == 3'b000);
      lf = nxt(lf); v = (lf[1:0] != 2'b00);
      lf = nxt(lf);
      op = (lf[3:0] == 4'hF) ? lf[9:4] : ops[lf[6:4] % 6];
      step((i % 500) == 499, st, bb, v, op, lf[15:8]);
    end
    // R1: reset in the middle of traffic
    step(0, 0, 0, 1, 6'h23, 8'hD0);
    step(0, 0, 0, 1, 6'h00, 8'hD1);
    step(1, 0, 0, 1, 6'h2B, 8'hD2);
    chk("R1", "ex_valid after reset", ex_valid, 0);
    chk("R1", "wb_rf_wr_en after reset", wb_rf_wr_en, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule